// File: doc/BRIEF.md
# Single-Wire Bus Slave Network Command Layer

This block is the network-layer controller of a slave on a single-conductor bus. A separate time-slot engine turns the line waveform into single-clock events: a bus reset (with a flag telling whether the reset pulse had overdrive length), a bit written by the master, and a request for the next bit the slave must return. The controller answers each reset with a presence pulse. It then gathers a one-byte network command and performs one of seven selection procedures. These read out, match or arbitrate against a 64-bit identity, or skip or resume selection. The identity is a family byte, a 48-bit serial number and a CRC-8 byte that is computed at elaboration time.

Two flags follow the bus traffic. The resume flag records that this slave was the last one addressed by a matching or arbitration procedure. The overdrive flag records that the bus runs at the faster speed. When selection succeeds, a one-clock `selected` pulse hands the bus to the memory-function layer. The controller then ignores all bit traffic until the next reset. A slave that is not addressed releases the line (returns 1 on every read slot) until the next reset.

Top module: `owire_rom_layer`

## Requirements
- R1: Every reset event is followed, in the next clock, by a one-clock `presence` pulse, and the slave then expects a command byte, least significant bit first.
- R2: A reset event with `ev_reset_od`=0 clears `od_mode`. A reset event with `ev_reset_od`=1 leaves `od_mode` unchanged.
- R3: A command byte other than 33h, 55h, F0h, CCh, A5h, 3Ch or 69h sends the slave idle: no `selected` pulse, and every read slot returns 1 until the next reset.
- R4: Command 33h (identity readout) clears `rc_flag`. The next 64 read slots return the identity LSB first: bits 0-7 are the family byte, bits 8-55 the serial number and bits 56-63 the CRC byte. The 64th slot produces `selected`.
- R5: Command CCh (skip) clears `rc_flag` and produces `selected` one clock after the last command bit.
- R6: Command 55h (match) clears `rc_flag`, then compares 64 written bits against the identity in order. A full match sets `rc_flag` and produces `selected`. Any mismatch sends the slave idle without `selected`.
- R7: Command F0h (arbitration) clears `rc_flag`, then handles each identity bit as a triplet: a read slot returns the bit, a read slot returns its complement, and a written bit is compared with it. A mismatch sends the slave idle. After 64 successful triplets, `rc_flag` is set and `selected` pulses.
- R8: Command 3Ch (overdrive skip) clears `rc_flag`, sets `od_mode` and produces `selected`.
- R9: Command 69h (overdrive match) clears `rc_flag`, sets `od_mode` and then matches like R6. On a mismatch, `od_mode` is cleared unless it was already 1 before the command.
- R10: Command A5h (resume) produces `selected` only when `rc_flag` is 1. Otherwise the slave goes idle and `rc_flag` keeps its value.
- R11: `selected` lasts exactly one clock. After it, written bits have no effect and read slots return 1 until the next reset.
- R12: The CRC byte is the CRC-8 (polynomial x^8+x^5+x^4+1, register starting at zero, data shifted in LSB first) of the family byte followed by the serial number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_reset | input | 1 | One-clock pulse: a bus reset was detected |
| ev_reset_od | input | 1 | Qualifies ev_reset: 1 when the reset pulse had overdrive length |
| ev_rx | input | 1 | One-clock pulse: the master wrote a bit |
| rx_bit | input | 1 | Value of the written bit, valid with ev_rx |
| ev_tx_req | input | 1 | One-clock pulse: the slot engine consumes the current tx_bit |
| tx_bit | output | 1 | Bit to return in the next read slot (1 = line released) |
| presence | output | 1 | One-clock pulse requesting a presence response |
| selected | output | 1 | One-clock pulse handing the bus to the memory layer |
| od_mode | output | 1 | Overdrive flag |
| rc_flag | output | 1 | Resume flag |

## Verification
The bench runs match and overdrive-match with a single wrong bit in the middle of the identity. A design that compared the wrong bit index, or kept going after a mismatch, would raise `selected` or drive identity bits afterwards. The overdrive-match mismatch is tried both from standard speed and from overdrive speed. A design that ignored the prior speed would either leave `od_mode` set on a standard bus or drop an established overdrive. Resume is issued once after a skip and once after a match, which catches a resume flag that is set or cleared by the wrong commands. Arbitration is run to completion and also broken off at one triplet, so a swapped bit and complement, or a missing dropout, shows up on `tx_bit`.

// File: rtl/owire_rom_pkg.sv
package owire_rom_pkg;

  localparam int FAM_W = 8;
  localparam int SER_W = 48;
  localparam int CRC_W = 8;
  localparam int ID_W  = FAM_W + SER_W + CRC_W;
  localparam int CMD_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_SEARCH,
    ST_MEM
  } rom_state_e;

  localparam logic [CMD_W-1:0] CMD_READ     = 8'h33;
  localparam logic [CMD_W-1:0] CMD_MATCH    = 8'h55;
  localparam logic [CMD_W-1:0] CMD_SEARCH   = 8'hF0;
  localparam logic [CMD_W-1:0] CMD_SKIP     = 8'hCC;
  localparam logic [CMD_W-1:0] CMD_RESUME   = 8'hA5;
  localparam logic [CMD_W-1:0] CMD_OD_SKIP  = 8'h3C;
  localparam logic [CMD_W-1:0] CMD_OD_MATCH = 8'h69;

  // CRC-8, x^8+x^5+x^4+1, reflected form, data LSB first
  function automatic logic [CRC_W-1:0] id_crc8(input logic [FAM_W+SER_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = 0; i < FAM_W + SER_W; i++) begin
      fb = c[0] ^ d[i];
      c  = {1'b0, c[CRC_W-1:1]};
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

endpackage

// File: rtl/owire_id_store.sv
module owire_id_store
  import owire_rom_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY = 8'h2D,
  parameter logic [SER_W-1:0] SERIAL = 48'h0A1B_3C4D_5E6F
) (
  output logic [ID_W-1:0] id_word
);
  localparam logic [CRC_W-1:0] ID_CRC = id_crc8({SERIAL, FAMILY});

  assign id_word = {ID_CRC, SERIAL, FAMILY};
endmodule

// File: rtl/owire_byte_rx.sv
module owire_byte_rx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              stb,
  input  logic              bit_in,
  output logic              done,
  output logic [BYTE_W-1:0] byte_val
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-2:0] sh_q, sh_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              en;

  assign byte_val = {bit_in, sh_q};
  assign done     = stb && (cnt_q == CNT_LAST);
  assign en       = clr || stb;

  always_comb begin
    sh_n  = sh_q;
    cnt_n = cnt_q;
    if (clr) begin
      cnt_n = '0;
    end else if (stb) begin
      sh_n  = byte_val[BYTE_W-1:1];
      cnt_n = done ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (en) begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/owire_rom_flags.sv
module owire_rom_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic od_set,
  input  logic od_clr,
  input  logic rc_set,
  input  logic rc_clr,
  output logic od_q,
  output logic rc_q
);
  logic od_n, rc_n, en;

  assign en = od_set || od_clr || rc_set || rc_clr;

  always_comb begin
    od_n = od_q;
    rc_n = rc_q;
    if (od_set)      od_n = 1'b1;
    else if (od_clr) od_n = 1'b0;
    if (rc_set)      rc_n = 1'b1;
    else if (rc_clr) rc_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_q <= 1'b0;
      rc_q <= 1'b0;
    end else if (en) begin
      od_q <= od_n;
      rc_q <= rc_n;
    end
  end
endmodule

// File: rtl/owire_rom_layer.sv
module owire_rom_layer
  import owire_rom_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY_CODE = 8'h2D,
  parameter logic [SER_W-1:0] SERIAL_NUM  = 48'h0A1B_3C4D_5E6F
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_reset,
  input  logic ev_reset_od,
  input  logic ev_rx,
  input  logic rx_bit,
  input  logic ev_tx_req,
  output logic tx_bit,
  output logic presence,
  output logic selected,
  output logic od_mode,
  output logic rc_flag
);
  localparam int IDX_W = $clog2(ID_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_W - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  rom_state_e       state_q, state_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [1:0]       ph_q, ph_n;
  logic             odm_q, odm_n;
  logic             odb_q, odb_n;
  logic             sel_n;
  logic             od_set, od_clr, rc_set, rc_clr;
  logic [ID_W-1:0]  id_word;
  logic             id_bit;
  logic             cmd_done;
  logic [CMD_W-1:0] cmd_byte;
  logic             cmd_stb;

  owire_id_store #(.FAMILY(FAMILY_CODE), .SERIAL(SERIAL_NUM)) u_id (
    .id_word(id_word)
  );

  assign cmd_stb = ev_rx && !ev_reset && (state_q == ST_CMD);

  owire_byte_rx #(.BYTE_W(CMD_W)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_q),
    .clr     (ev_reset),
    .stb     (cmd_stb),
    .bit_in  (rx_bit),
    .done    (cmd_done),
    .byte_val(cmd_byte)
  );

  owire_rom_flags u_flags (
    .clk   (clk),
    .rst_n (rst_q),
    .od_set(od_set),
    .od_clr(od_clr),
    .rc_set(rc_set),
    .rc_clr(rc_clr),
    .od_q  (od_mode),
    .rc_q  (rc_flag)
  );

  assign id_bit = id_word[idx_q];

  always_comb begin
    tx_bit = 1'b1;
    case (state_q)
      ST_READ:   tx_bit = id_bit;
      ST_SEARCH: if (ph_q == 2'd0) tx_bit = id_bit;
                 else if (ph_q == 2'd1) tx_bit = ~id_bit;
      default:   tx_bit = 1'b1;
    endcase
  end

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    ph_n    = ph_q;
    odm_n   = odm_q;
    odb_n   = odb_q;
    sel_n   = 1'b0;
    od_set  = 1'b0;
    od_clr  = 1'b0;
    rc_set  = 1'b0;
    rc_clr  = 1'b0;
    if (ev_reset) begin
      state_n = ST_CMD;
      idx_n   = '0;
      ph_n    = 2'd0;
      od_clr  = !ev_reset_od;
    end else begin
      case (state_q)
        ST_CMD: if (cmd_done) begin
          idx_n = '0;
          ph_n  = 2'd0;
          case (cmd_byte)
            CMD_READ:   begin rc_clr = 1'b1; state_n = ST_READ; end
            CMD_MATCH:  begin rc_clr = 1'b1; odm_n = 1'b0; state_n = ST_MATCH; end
            CMD_SEARCH: begin rc_clr = 1'b1; state_n = ST_SEARCH; end
            CMD_SKIP:   begin rc_clr = 1'b1; sel_n = 1'b1; state_n = ST_MEM; end
            CMD_RESUME: begin
              if (rc_flag) begin sel_n = 1'b1; state_n = ST_MEM; end
              else state_n = ST_IDLE;
            end
            CMD_OD_SKIP: begin
              rc_clr = 1'b1; od_set = 1'b1; sel_n = 1'b1; state_n = ST_MEM;
            end
            CMD_OD_MATCH: begin
              rc_clr = 1'b1; od_set = 1'b1; odm_n = 1'b1; odb_n = od_mode;
              state_n = ST_MATCH;
            end
            default: state_n = ST_IDLE;
          endcase
        end
        ST_READ: if (ev_tx_req) begin
          if (idx_q == IDX_LAST) begin sel_n = 1'b1; state_n = ST_MEM; end
          else idx_n = idx_q + 1'b1;
        end
        ST_MATCH: if (ev_rx) begin
          if (rx_bit != id_bit) begin
            state_n = ST_IDLE;
            od_clr  = odm_q && !odb_q;
          end else if (idx_q == IDX_LAST) begin
            rc_set = 1'b1; sel_n = 1'b1; state_n = ST_MEM;
          end else begin
            idx_n = idx_q + 1'b1;
          end
        end
        ST_SEARCH: begin
          if (ev_tx_req && ph_q != 2'd2) begin
            ph_n = ph_q + 2'd1;
          end else if (ev_rx && ph_q == 2'd2) begin
            ph_n = 2'd0;
            if (rx_bit != id_bit) begin
              state_n = ST_IDLE;
            end else if (idx_q == IDX_LAST) begin
              rc_set = 1'b1; sel_n = 1'b1; state_n = ST_MEM;
            end else begin
              idx_n = idx_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      ph_q     <= 2'd0;
      odm_q    <= 1'b0;
      odb_q    <= 1'b0;
      presence <= 1'b0;
      selected <= 1'b0;
    end else begin
      state_q  <= state_n;
      idx_q    <= idx_n;
      ph_q     <= ph_n;
      odm_q    <= odm_n;
      odb_q    <= odb_n;
      presence <= ev_reset;
      selected <= sel_n;
    end
  end

  assert_presence_R1: assert property (@(posedge clk) disable iff (!rst_q)
    ev_reset |=> presence);
  assert_std_reset_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (ev_reset && !ev_reset_od) |=> !od_mode);
  assert_od_reset_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (ev_reset && ev_reset_od) |=> (od_mode == $past(od_mode)));
  assert_sel_pulse_R11: assert property (@(posedge clk) disable iff (!rst_q)
    selected |=> !selected);
  assert_mismatch_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q == ST_MATCH && ev_rx && !ev_reset && rx_bit != id_bit) |=> !selected);
  assert_resume_R10: assert property (@(posedge clk) disable iff (!rst_q)
    (cmd_done && !ev_reset && cmd_byte == CMD_RESUME && !rc_flag) |=> (!selected && !rc_flag));
  assert_od_skip_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (cmd_done && !ev_reset && cmd_byte == CMD_OD_SKIP) |=> (od_mode && !rc_flag && selected));
endmodule

// File: tb/owire_rom_layer_bench.sv
module owire_rom_layer_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0]  FAM = 8'h2D;
  localparam logic [47:0] SER = 48'h0A1B_3C4D_5E6F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_reset = 1'b0, ev_reset_od = 1'b0, ev_rx = 1'b0, rx_bit = 1'b0, ev_tx_req = 1'b0;
  logic tx_bit, presence, selected, od_mode, rc_flag;

  int checks = 0;
  int failures = 0;
  int sel_cnt = 0;
  bit chk_en = 1'b0;
  logic [63:0] idb;

  // reference model state
  int m_state = 0; // 0 idle 1 cmd 2 read 3 match 4 search 5 mem
  int m_idx = 0, m_ph = 0, m_cnt = 0;
  logic [7:0] m_byte = '0;
  bit m_rc = 0, m_od = 0, m_odm = 0, m_odb = 0, m_pres = 0, m_sel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  owire_rom_layer #(.FAMILY_CODE(FAM), .SERIAL_NUM(SER)) u_owire_rom_layer (
    .clk(clk), .rst_n(rst_n), .ev_reset(ev_reset), .ev_reset_od(ev_reset_od),
    .ev_rx(ev_rx), .rx_bit(rx_bit), .ev_tx_req(ev_tx_req), .tx_bit(tx_bit),
    .presence(presence), .selected(selected), .od_mode(od_mode), .rc_flag(rc_flag)
  );

  function automatic logic [7:0] ref_crc(input logic [55:0] d);
    logic [7:0] r = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic x = r[0] ^ d[i];
      r = r >> 1;
      r[7] = x;
      r[3] = r[3] ^ x;
      r[2] = r[2] ^ x;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_rc = 0; m_od = 0; m_pres = 0; m_sel = 0; m_cnt = 0;
    end else begin
      m_pres = 0; m_sel = 0;
      if (ev_reset) begin
        m_pres = 1; if (!ev_reset_od) m_od = 0;
        m_state = 1; m_cnt = 0; m_idx = 0; m_ph = 0;
      end else if (m_state == 1 && ev_rx) begin
        m_byte = {rx_bit, m_byte[7:1]}; m_cnt++;
        if (m_cnt == 8) begin
          m_cnt = 0; m_idx = 0; m_ph = 0;
          case (m_byte)
            8'h33: begin m_rc = 0; m_state = 2; end
            8'h55: begin m_rc = 0; m_odm = 0; m_state = 3; end
            8'hF0: begin m_rc = 0; m_state = 4; end
            8'hCC: begin m_rc = 0; m_sel = 1; m_state = 5; end
            8'hA5: if (m_rc) begin m_sel = 1; m_state = 5; end else m_state = 0;
            8'h3C: begin m_rc = 0; m_od = 1; m_sel = 1; m_state = 5; end
            8'h69: begin m_rc = 0; m_odb = m_od; m_od = 1; m_odm = 1; m_state = 3; end
            default: m_state = 0;
          endcase
        end
      end else if (m_state == 2 && ev_tx_req) begin
        if (m_idx == 63) begin m_sel = 1; m_state = 5; end else m_idx++;
      end else if (m_state == 3 && ev_rx) begin
        if (rx_bit != idb[m_idx]) begin m_state = 0; if (m_odm && !m_odb) m_od = 0; end
        else if (m_idx == 63) begin m_rc = 1; m_sel = 1; m_state = 5; end
        else m_idx++;
      end else if (m_state == 4) begin
        if (ev_tx_req && m_ph != 2) m_ph++;
        else if (ev_rx && m_ph == 2) begin
          m_ph = 0;
          if (rx_bit != idb[m_idx]) m_state = 0;
          else if (m_idx == 63) begin m_rc = 1; m_sel = 1; m_state = 5; end
          else m_idx++;
        end
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (selected) sel_cnt++;
    if (chk_en) begin
      bit etx;
      etx = 1'b1;
      if (m_state == 2) etx = idb[m_idx];
      else if (m_state == 4 && m_ph == 0) etx = idb[m_idx];
      else if (m_state == 4 && m_ph == 1) etx = ~idb[m_idx];
      chk(tx_bit == etx, "R4 tx_bit", tx_bit, etx);
      chk(presence == m_pres, "R1 presence", presence, m_pres);
      chk(selected == m_sel, "R11 selected", selected, m_sel);
      chk(od_mode == m_od, "R2 od_mode", od_mode, m_od);
      chk(rc_flag == m_rc, "R6 rc_flag", rc_flag, m_rc);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_reset(input bit od);
    @(negedge clk); ev_reset = 1; ev_reset_od = od;
    @(negedge clk); ev_reset = 0; ev_reset_od = 0;
    chk(presence == 1'b1, "R1 presence after reset", presence, 1);
  endtask

  task automatic wr_bit(input bit b);
    @(negedge clk); ev_rx = 1; rx_bit = b;
    @(negedge clk); ev_rx = 0;
  endtask

  task automatic rd_bit(output bit b);
    @(negedge clk); b = tx_bit; ev_tx_req = 1;
    @(negedge clk); ev_tx_req = 0;
  endtask

  task automatic wr_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) wr_bit(v[i]);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int s0;
    bit b, c;
    logic [63:0] got;
    idb = {ref_crc({SER, FAM}), SER, FAM};
    idle(3);
    rst_n = 1;
    idle(5);
    chk(presence == 0 && selected == 0 && od_mode == 0 && rc_flag == 0 && tx_bit == 1,
        "R1 reset state", {presence, selected, od_mode, rc_flag, tx_bit}, 5'b00001);
    chk_en = 1;

    // R4 R12 identity readout
    bus_reset(0); wr_byte(8'h33);
    for (int i = 0; i < 64; i++) begin rd_bit(b); got[i] = b; end
    idle(2);
    chk(got == idb, "R4 identity bits", int'(got[31:0]), int'(idb[31:0]));
    chk(got[63:56] == ref_crc({SER, FAM}), "R12 crc byte", got[63:56], ref_crc({SER, FAM}));
    chk(sel_cnt == 1, "R4 selected after readout", sel_cnt, 1);
    rd_bit(b); wr_bit(0); idle(1);
    chk(b == 1, "R11 released after selection", b, 1);

    // R5 skip then R10 resume refused
    s0 = sel_cnt; bus_reset(0); wr_byte(8'hCC); idle(2);
    chk(sel_cnt == s0 + 1 && rc_flag == 0, "R5 skip selects", sel_cnt - s0, 1);
    s0 = sel_cnt; bus_reset(0); wr_byte(8'hA5); idle(2);
    chk(sel_cnt == s0, "R10 resume without rc", sel_cnt - s0, 0);
    rd_bit(b); chk(b == 1, "R10 idle after refused resume", b, 1);

    // R6 match success, then R10 resume
    s0 = sel_cnt; bus_reset(0); wr_byte(8'h55);
    for (int i = 0; i < 64; i++) wr_bit(idb[i]);
    idle(2);
    chk(sel_cnt == s0 + 1 && rc_flag == 1, "R6 match selects", rc_flag, 1);
    s0 = sel_cnt; bus_reset(0); wr_byte(8'hA5); idle(2);
    chk(sel_cnt == s0 + 1, "R10 resume with rc", sel_cnt - s0, 1);

    // R6 match with mismatch at bit 10
    s0 = sel_cnt; bus_reset(0); wr_byte(8'h55);
    for (int i = 0; i < 64; i++) wr_bit(i == 10 ? ~idb[i] : idb[i]);
    idle(2);
    chk(sel_cnt == s0 && rc_flag == 0, "R6 mismatch no select", sel_cnt - s0, 0);
    rd_bit(b); chk(b == 1, "R6 idle after mismatch", b, 1);

    // R7 full arbitration
    s0 = sel_cnt; bus_reset(0); wr_byte(8'hF0);
    for (int i = 0; i < 64; i++) begin
      rd_bit(b); rd_bit(c);
      if (i == 0 || i == 63) chk(b == idb[i] && c == ~idb[i], "R7 triplet bits", {b, c}, {idb[i], ~idb[i]});
      wr_bit(b);
    end
    idle(2);
    chk(sel_cnt == s0 + 1 && rc_flag == 1, "R7 arbitration selects", sel_cnt - s0, 1);
    // R7 dropout at bit 5
    s0 = sel_cnt; bus_reset(0); wr_byte(8'hF0);
    for (int i = 0; i < 6; i++) begin rd_bit(b); rd_bit(c); wr_bit(i == 5 ? c : b); end
    rd_bit(b); rd_bit(c); idle(1);
    chk(b == 1 && c == 1 && sel_cnt == s0, "R7 dropout releases", {b, c}, 2'b11);

    // R8 overdrive skip, R2 overdrive reset keeps od
    s0 = sel_cnt; bus_reset(0); wr_byte(8'h3C); idle(2);
    chk(od_mode == 1 && rc_flag == 0 && sel_cnt == s0 + 1, "R8 od skip", od_mode, 1);
    bus_reset(1); idle(1);
    chk(od_mode == 1, "R2 od reset keeps od", od_mode, 1);
    // R9 od match mismatch while already in overdrive
    wr_byte(8'h69);
    for (int i = 0; i < 20; i++) wr_bit(i == 3 ? ~idb[i] : idb[i]);
    idle(2);
    chk(od_mode == 1, "R9 od kept on mismatch", od_mode, 1);
    bus_reset(0); idle(1);
    chk(od_mode == 0, "R2 std reset clears od", od_mode, 0);
    // R9 od match mismatch from standard speed
    wr_byte(8'h69); idle(1);
    chk(od_mode == 1, "R9 od set by command", od_mode, 1);
    wr_bit(idb[0]); wr_bit(~idb[1]); idle(2);
    chk(od_mode == 0, "R9 od cleared on mismatch", od_mode, 0);
    // R9 od match success
    s0 = sel_cnt; bus_reset(0); wr_byte(8'h69);
    for (int i = 0; i < 64; i++) wr_bit(idb[i]);
    idle(2);
    chk(od_mode == 1 && rc_flag == 1 && sel_cnt == s0 + 1, "R9 od match selects", {od_mode, rc_flag}, 2'b11);

    // R3 unknown command
    s0 = sel_cnt; bus_reset(1); wr_byte(8'h12);
    rd_bit(b); wr_byte(8'hCC); idle(2);
    chk(sel_cnt == s0 && b == 1, "R3 unknown code idle", sel_cnt - s0, 0);

    idle(4);
    finish_run();
  end
endmodule